// File: doc/BRIEF.md
# Reset Boot Mode Selector

This block settles, at the moment reset is released, where code execution begins and whether the boot memory is visible in the code space. It looks at an active-low in-system-programming pin, a boot-jump fuse bit (0 means programmed), and a software boot vector byte. It captures all three on the first clock after reset goes high and holds them until the next reset. From that capture it produces the boot-enable flag, the 16-bit start address and the power-up value of the flash control register.

A second stage models the choice the boot-area code makes next. When execution starts in the boot area, the block reports whether the built-in loader runs or whether a user loader located by the software boot vector runs. A comparator tells whether a given code address falls in the mapped boot window. Software can rewrite the boot-enable flag at any time after the capture.

Top module: `boot_mode_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `ready_o`=0, `boot_en_o`=0, `start_addr_o`=0000h, `fctl_init_o`=F0h and `boot_src_o`=0.
- R2: On the first rising edge with `rst_n` high, if `isp_n_i` is 0, the block sets `boot_en_o`=1, `start_addr_o`=F000h, `fctl_init_o`=00h and `boot_src_o`=1. This holds whatever the fuse is.
- R3: On that edge, if `isp_n_i` is 1 and `jump_fuse_i` is 0, the block sets `boot_en_o`=1, `start_addr_o`=F000h, `fctl_init_o`=F0h and `boot_src_o`=2.
- R4: On that edge, if `isp_n_i` is 1 and `jump_fuse_i` is 1, the block sets `boot_en_o`=0, `start_addr_o`=0000h, `fctl_init_o`=F0h and `boot_src_o`=3.
- R5: `ready_o` rises on that edge. Once it is high, later changes on `isp_n_i`, `jump_fuse_i` or `sw_vec_i` leave `start_addr_o`, `fctl_init_o`, `boot_src_o`, `loader_sel_o` and `loader_addr_o` unchanged until the next reset.
- R6: `loader_sel_o` (0 = application, 1 = built-in loader, 2 = user loader) has three cases:
  - It is 0 with `loader_addr_o`=0000h when the start address is 0000h.
  - It is 1 with `loader_addr_o`=F000h when the start address is F000h and `fctl_init_o` is 00h.
  - Otherwise it depends on the captured vector. A captured vector below F0h gives 2, with `loader_addr_o` = {vector, 00h}. Any other value gives 1 with F000h.
- R7: When `ready_o` is high, a write (`bootbit_wr_i`=1) loads `bootbit_wdata_i` into `boot_en_o` on the next edge. A write made while in reset, or on the capture edge, is ignored.
- R8: `boot_hit_o` is 1 only when `boot_en_o` is 1 and `code_addr_i` lies in F000h..FFFFh.
- R9: Vector boundary: a captured vector of EFh gives a user loader at EF00h. A captured vector of F0h, which is the blank-part default, gives the built-in loader. With fuse 1 and the pin high, a blank part starts the application at 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| isp_n_i | input | 1 | In-system-programming request pin, active low |
| jump_fuse_i | input | 1 | Boot-jump fuse, 0 = programmed |
| sw_vec_i | input | 8 | Software boot vector byte |
| bootbit_wr_i | input | 1 | Software write strobe for the boot-enable flag |
| bootbit_wdata_i | input | 1 | Value written to the boot-enable flag |
| code_addr_i | input | 16 | Code address to test against the boot window |
| ready_o | output | 1 | Reset decision captured |
| boot_en_o | output | 1 | Boot memory mapped into code space |
| start_addr_o | output | 16 | Execution start address |
| fctl_init_o | output | 8 | Initial flash control register value |
| boot_src_o | output | 2 | Deciding cause: 0 none, 1 pin, 2 fuse, 3 default |
| loader_sel_o | output | 2 | 0 application, 1 built-in loader, 2 user loader |
| loader_addr_o | output | 16 | Entry address of the selected code |
| boot_hit_o | output | 1 | `code_addr_i` falls in the mapped boot window |

## Verification
The assertions cover the relations that hold on every cycle:
- the start address, control value and cause stay frozen after capture;
- the pin cause always carries control value 00h;
- a user loader is chosen only from the boot area, with a vector below the limit;
- a window hit implies the flag is set and the address is in range;
- a software write lands on the flag one edge later.

The bench scenarios show what no single-cycle property can. These are the pin-over-fuse priority under every pin and fuse combination, and the fact that later pin, fuse and vector changes are ignored. They also cover the EFh/F0h vector boundary and writes dropped during reset or on the capture edge. A behavioural model is compared on every clock.

// File: rtl/boot_sel_pkg.sv
// Package: shared encodings for the reset boot mode selector.
// Assumes: two-bit codes are enough for the cause and the loader choice.
package boot_sel_pkg;
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_PIN     = 2'd1,
        SRC_FUSE    = 2'd2,
        SRC_DEFAULT = 2'd3
    } boot_src_e;

    typedef enum logic [1:0] {
        LDR_APP     = 2'd0,
        LDR_BUILTIN = 2'd1,
        LDR_USER    = 2'd2,
        LDR_RSVD    = 2'd3
    } loader_e;
endpackage

// File: rtl/boot_priority_decode.sv
// Module: boot_priority_decode
// Combinational priority between the programming pin and the jump fuse.
// The pin wins over the fuse, and the fuse wins over the default path.
// Assumes: inputs are already stable when the sampler captures the result.
module boot_priority_decode
    import boot_sel_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
    parameter logic [BYTE_W-1:0] FCTL_PIN  = 8'h00,
    parameter logic [BYTE_W-1:0] FCTL_DFLT = 8'hF0
) (
    input  logic              pin_n,
    input  logic              fuse,
    output logic              dec_en,
    output logic [ADDR_W-1:0] dec_start,
    output logic [BYTE_W-1:0] dec_fctl,
    output boot_src_e         dec_src
);
    // Priority selection of the three boot causes.
    always_comb begin
        if (!pin_n) begin
            dec_en    = 1'b1;
            dec_start = BOOT_BASE;
            dec_fctl  = FCTL_PIN;
            dec_src   = SRC_PIN;
        end else if (!fuse) begin
            dec_en    = 1'b1;
            dec_start = BOOT_BASE;
            dec_fctl  = FCTL_DFLT;
            dec_src   = SRC_FUSE;
        end else begin
            dec_en    = 1'b0;
            dec_start = '0;
            dec_fctl  = FCTL_DFLT;
            dec_src   = SRC_DEFAULT;
        end
    end
endmodule

// File: rtl/boot_latch.sv
// Module: boot_latch
// Captures the decoded reset decision and the software vector on the first
// clock after reset release, then holds them. It also owns the boot-enable
// flag, which software may rewrite once the capture is done.
// Assumes: synchronous active-low reset; a write on the capture edge loses.
module boot_latch
    import boot_sel_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] FCTL_DFLT = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic [ADDR_W-1:0] dec_start,
    input  logic [BYTE_W-1:0] dec_fctl,
    input  boot_src_e         dec_src,
    input  logic [BYTE_W-1:0] vec_in,
    input  logic              wr,
    input  logic              wdata,
    output logic              ready,
    output logic              en,
    output logic [ADDR_W-1:0] start,
    output logic [BYTE_W-1:0] fctl,
    output logic [BYTE_W-1:0] vec,
    output boot_src_e         src
);
    logic capture;
    assign capture = !ready;

    // Capture-once register set for the reset decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            start <= '0;
            fctl  <= FCTL_DFLT;
            vec   <= '0;
            src   <= SRC_NONE;
        end else if (capture) begin
            ready <= 1'b1;
            start <= dec_start;
            fctl  <= dec_fctl;
            vec   <= vec_in;
            src   <= dec_src;
        end
    end

    // Boot-enable flag: seeded by the capture, then software writable.
    always_ff @(posedge clk) begin
        if (!rst_n)       en <= 1'b0;
        else if (capture) en <= dec_en;
        else if (wr)      en <= wdata;
    end

    a_r5_hold_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> ($stable(start) && $stable(fctl) && $stable(src) && $stable(vec)));

    a_r7_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ready) && $past(wr)) |-> (en == $past(wdata)));
endmodule

// File: rtl/loader_select.sv
// Module: loader_select
// Second-stage choice made by the boot-area code: built-in loader, user
// loader at {vector, 00h}, or the application when not starting in boot.
// Assumes: the inputs are held registers, so the output is stable.
module loader_select
    import boot_sel_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
    parameter logic [BYTE_W-1:0] FCTL_PIN  = 8'h00,
    parameter logic [BYTE_W-1:0] VEC_LIMIT = 8'hF0
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [BYTE_W-1:0] fctl,
    input  logic [BYTE_W-1:0] vec,
    output loader_e           sel,
    output logic [ADDR_W-1:0] entry
);
    localparam int PAD_W = ADDR_W - BYTE_W;

    // Loader choice and entry address.
    always_comb begin
        if (start != BOOT_BASE) begin
            sel   = LDR_APP;
            entry = start;
        end else if (fctl == FCTL_PIN) begin
            sel   = LDR_BUILTIN;
            entry = BOOT_BASE;
        end else if (vec < VEC_LIMIT) begin
            sel   = LDR_USER;
            entry = {vec, {PAD_W{1'b0}}};
        end else begin
            sel   = LDR_BUILTIN;
            entry = BOOT_BASE;
        end
    end
endmodule

// File: rtl/boot_region_decode.sv
// Module: boot_region_decode
// Tells whether a code address lies in the mapped boot window.
// Assumes: the window is a power-of-two block aligned to its size.
module boot_region_decode #(
    parameter int ADDR_W    = 16,
    parameter int BOOT_SIZE = 4096,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int OFF_W = $clog2(BOOT_SIZE);

    // Upper-bit compare gated by the enable flag.
    always_comb hit = en && (addr[ADDR_W-1:OFF_W] == BOOT_BASE[ADDR_W-1:OFF_W]);
endmodule

// File: rtl/boot_mode_select.sv
// Module: boot_mode_select (top)
// Reset-time boot decision, boot-enable flag, loader choice and window test.
// Assumes: synchronous active-low reset held for at least one clock edge.
module boot_mode_select
    import boot_sel_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BYTE_W    = 8,
    parameter int BOOT_SIZE = 4096,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
    parameter logic [BYTE_W-1:0] FCTL_PIN  = 8'h00,
    parameter logic [BYTE_W-1:0] FCTL_DFLT = 8'hF0,
    parameter logic [BYTE_W-1:0] VEC_LIMIT = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              isp_n_i,
    input  logic              jump_fuse_i,
    input  logic [BYTE_W-1:0] sw_vec_i,
    input  logic              bootbit_wr_i,
    input  logic              bootbit_wdata_i,
    input  logic [ADDR_W-1:0] code_addr_i,
    output logic              ready_o,
    output logic              boot_en_o,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic [BYTE_W-1:0] fctl_init_o,
    output logic [1:0]        boot_src_o,
    output logic [1:0]        loader_sel_o,
    output logic [ADDR_W-1:0] loader_addr_o,
    output logic              boot_hit_o
);
    logic              dec_en;
    logic [ADDR_W-1:0] dec_start;
    logic [BYTE_W-1:0] dec_fctl;
    boot_src_e         dec_src;
    boot_src_e         held_src;
    logic [BYTE_W-1:0] held_vec;
    loader_e           ldr;

    boot_priority_decode #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BOOT_BASE(BOOT_BASE),
        .FCTL_PIN(FCTL_PIN), .FCTL_DFLT(FCTL_DFLT)
    ) u_dec (
        .pin_n(isp_n_i), .fuse(jump_fuse_i),
        .dec_en(dec_en), .dec_start(dec_start), .dec_fctl(dec_fctl), .dec_src(dec_src)
    );

    boot_latch #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .FCTL_DFLT(FCTL_DFLT)
    ) u_latch (
        .clk(clk), .rst_n(rst_n),
        .dec_en(dec_en), .dec_start(dec_start), .dec_fctl(dec_fctl), .dec_src(dec_src),
        .vec_in(sw_vec_i), .wr(bootbit_wr_i), .wdata(bootbit_wdata_i),
        .ready(ready_o), .en(boot_en_o), .start(start_addr_o), .fctl(fctl_init_o),
        .vec(held_vec), .src(held_src)
    );

    loader_select #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BOOT_BASE(BOOT_BASE),
        .FCTL_PIN(FCTL_PIN), .VEC_LIMIT(VEC_LIMIT)
    ) u_ldr (
        .start(start_addr_o), .fctl(fctl_init_o), .vec(held_vec),
        .sel(ldr), .entry(loader_addr_o)
    );

    boot_region_decode #(
        .ADDR_W(ADDR_W), .BOOT_SIZE(BOOT_SIZE), .BOOT_BASE(BOOT_BASE)
    ) u_region (
        .en(boot_en_o), .addr(code_addr_i), .hit(boot_hit_o)
    );

    // Enum outputs flattened onto plain ports.
    assign boot_src_o   = held_src;
    assign loader_sel_o = ldr;

    a_r2_pin_seeds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && boot_src_o == SRC_PIN) |-> (fctl_init_o == FCTL_PIN && start_addr_o == BOOT_BASE));

    a_r6_user_loader: assert property (@(posedge clk) disable iff (!rst_n)
        (loader_sel_o == LDR_USER) |-> (start_addr_o == BOOT_BASE && fctl_init_o != FCTL_PIN
            && loader_addr_o[ADDR_W-BYTE_W-1:0] == '0 && loader_addr_o[ADDR_W-1:ADDR_W-BYTE_W] < VEC_LIMIT));

    a_r4_app_path: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_addr_o != BOOT_BASE) |-> (loader_sel_o == LDR_APP && fctl_init_o == FCTL_DFLT));

    a_r8_window_hit: assert property (@(posedge clk) disable iff (!rst_n)
        boot_hit_o |-> (boot_en_o && code_addr_i >= BOOT_BASE));
endmodule

// File: tb/tb_boot_mode_select.sv
module tb_boot_mode_select;
    localparam int CLK_P = 10;
    localparam int Q     = CLK_P / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        isp_n_i = 1'b1;
    logic        jump_fuse_i = 1'b1;
    logic [7:0]  sw_vec_i = 8'hF0;
    logic        bootbit_wr_i = 1'b0;
    logic        bootbit_wdata_i = 1'b0;
    logic [15:0] code_addr_i = 16'h0000;
    logic        ready_o, boot_en_o, boot_hit_o;
    logic [15:0] start_addr_o, loader_addr_o;
    logic [7:0]  fctl_init_o;
    logic [1:0]  boot_src_o, loader_sel_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    boot_mode_select dut (
        .clk(clk), .rst_n(rst_n), .isp_n_i(isp_n_i), .jump_fuse_i(jump_fuse_i),
        .sw_vec_i(sw_vec_i), .bootbit_wr_i(bootbit_wr_i), .bootbit_wdata_i(bootbit_wdata_i),
        .code_addr_i(code_addr_i), .ready_o(ready_o), .boot_en_o(boot_en_o),
        .start_addr_o(start_addr_o), .fctl_init_o(fctl_init_o), .boot_src_o(boot_src_o),
        .loader_sel_o(loader_sel_o), .loader_addr_o(loader_addr_o), .boot_hit_o(boot_hit_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural reference model
    bit          m_ready = 0, m_en = 0;
    int          m_start = 0, m_fctl = 'hF0, m_vec = 0, m_src = 0;
    bit          model_live = 0;

    always @(posedge clk) begin
        model_live <= 1;
        if (!rst_n) begin
            m_ready <= 0; m_en <= 0; m_start <= 0; m_fctl <= 'hF0; m_vec <= 0; m_src <= 0;
        end else if (!m_ready) begin
            m_ready <= 1;
            m_vec   <= sw_vec_i;
            if (!isp_n_i)          begin m_en <= 1; m_start <= 'hF000; m_fctl <= 'h00; m_src <= 1; end
            else if (!jump_fuse_i) begin m_en <= 1; m_start <= 'hF000; m_fctl <= 'hF0; m_src <= 2; end
            else                   begin m_en <= 0; m_start <= 0;      m_fctl <= 'hF0; m_src <= 3; end
        end else if (bootbit_wr_i) begin
            m_en <= bootbit_wdata_i;
        end
    end

    function automatic int exp_ldr();
        if (m_start != 'hF000) return 0;
        if (m_fctl == 0) return 1;
        if (m_vec < 'hF0) return 2;
        return 1;
    endfunction

    function automatic int exp_ldr_addr();
        if (m_start != 'hF000) return 0;
        if (exp_ldr() == 2) return m_vec * 256;
        return 'hF000;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, a quarter period after each edge.
    always @(posedge clk) begin
        #(Q);
        if (model_live && !finished) begin
            chk("R1_R5 ready",         int'(ready_o),       int'(m_ready));
            chk("R2_R3_R4_R7 boot_en", int'(boot_en_o),     int'(m_en));
            chk("R2_R3_R4 start",      int'(start_addr_o),  m_start);
            chk("R2_R3_R4 fctl",       int'(fctl_init_o),   m_fctl);
            chk("R2_R3_R4 src",        int'(boot_src_o),    m_src);
            chk("R6 loader",           int'(loader_sel_o),  exp_ldr());
            chk("R6 loader_addr",      int'(loader_addr_o), exp_ldr_addr());
            chk("R8 hit",              int'(boot_hit_o),    int'(m_en && code_addr_i >= 16'hF000));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        @(posedge clk); #(Q);
    endtask

    task automatic restart(bit pin_n, bit fuse, logic [7:0] vec);
        @(negedge clk);
        rst_n = 0; isp_n_i = pin_n; jump_fuse_i = fuse; sw_vec_i = vec;
        cyc(2);
        rst_n = 1;
        settle();
    endtask

    initial begin
        // R1: reset state, with a software write attempted during reset
        isp_n_i = 0; bootbit_wr_i = 1; bootbit_wdata_i = 1;
        cyc(3);
        chk("R1 ready in reset", int'(ready_o), 0);
        chk("R1 fctl in reset", int'(fctl_init_o), 'hF0);
        chk("R7 write in reset ignored", int'(boot_en_o), 0);
        // Release: write on the capture edge loses to the decision (pin low -> en 1 anyway)
        bootbit_wdata_i = 0;
        rst_n = 1;
        settle();
        chk("R2 pin boot_en", int'(boot_en_o), 1);
        chk("R2 pin start", int'(start_addr_o), 'hF000);
        chk("R2 pin fctl", int'(fctl_init_o), 'h00);
        chk("R6 pin builtin", int'(loader_sel_o), 1);
        @(negedge clk); bootbit_wr_i = 0;
        // R5: later input changes ignored
        isp_n_i = 1; jump_fuse_i = 0; sw_vec_i = 8'h12;
        cyc(3);
        chk("R5 start held", int'(start_addr_o), 'hF000);
        chk("R5 fctl held", int'(fctl_init_o), 'h00);
        chk("R5 loader held", int'(loader_sel_o), 1);
        // R7/R8: software clears then sets boot-enable
        code_addr_i = 16'hF000; bootbit_wr_i = 1; bootbit_wdata_i = 0;
        settle();
        chk("R7 cleared", int'(boot_en_o), 0);
        chk("R8 no hit when cleared", int'(boot_hit_o), 0);
        @(negedge clk); bootbit_wdata_i = 1;
        settle();
        @(negedge clk); bootbit_wr_i = 0; code_addr_i = 16'hFFFF;
        #(Q); chk("R8 hit at FFFF", int'(boot_hit_o), 1);
        code_addr_i = 16'hEFFF;
        #(Q); chk("R8 miss at EFFF", int'(boot_hit_o), 0);

        // R3 with user loader
        restart(1, 0, 8'h12);
        chk("R3 fuse boot_en", int'(boot_en_o), 1);
        chk("R3 fuse fctl", int'(fctl_init_o), 'hF0);
        chk("R6 user loader", int'(loader_sel_o), 2);
        chk("R6 user addr", int'(loader_addr_o), 'h1200);

        // R9 boundary
        restart(1, 0, 8'hEF);
        chk("R9 EF user", int'(loader_addr_o), 'hEF00);
        restart(1, 0, 8'hF0);
        chk("R9 F0 builtin", int'(loader_sel_o), 1);
        chk("R9 F0 addr", int'(loader_addr_o), 'hF000);
        restart(1, 0, 8'hFF);
        chk("R6 FF builtin", int'(loader_sel_o), 1);

        // R4 blank part
        restart(1, 1, 8'hF0);
        chk("R4 app start", int'(start_addr_o), 0);
        chk("R4 boot_en", int'(boot_en_o), 0);
        chk("R9 blank app loader", int'(loader_sel_o), 0);
        @(negedge clk); code_addr_i = 16'hF800;
        #(Q); chk("R8 no map in app", int'(boot_hit_o), 0);
        bootbit_wr_i = 1; bootbit_wdata_i = 1;
        settle();
        @(negedge clk); bootbit_wr_i = 0;
        #(Q); chk("R7 set in app", int'(boot_hit_o), 1);
        chk("R7 start unchanged", int'(start_addr_o), 0);

        // R2 priority over fuse, pin wins with a low vector
        restart(0, 0, 8'h12);
        chk("R2 pin over fuse src", int'(boot_src_o), 1);
        chk("R6 pin ignores vector", int'(loader_sel_o), 1);
        cyc(2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule